// File: doc/BRIEF.md
# Carry-Completion Sensing Adder

This block adds two operands of `WIDTH` bits (unsigned or two's complement) plus a carry input. It is a clocked model of a self-timed adder: how long it takes depends on the operand values, not on a fixed worst-case latency. Each bit position holds a carry on two rails, one meaning "carry is one" and one meaning "carry is zero". A position with both rails low has not resolved yet.

A `start` pulse captures the operands. On that same edge, every position that generates a carry (both bits one) sets its one-rail. Every position that kills a carry (both bits zero) sets its zero-rail. Positions that propagate (bits differ) copy the rails of the position below them on each later clock. Position 0 copies the carry input. `done` rises once every position holds a resolved rail. The outputs `sum`, `carry_out` and `overflow` are valid while `done` is high. `cycles` reports how many clock edges the operation took, counting the start edge.

A new `start` abandons any operation in progress and begins the new one.

Top module: `carry_completion_adder`

## Requirements
- R1: While `done` is high, `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^WIDTH for the operands captured by the last `start`.
- R2: While `done` is high, `carry_out` equals bit WIDTH of the full-width sum of the captured operands and carry.
- R3: While `done` is high, `overflow` equals the carry out of the top bit XOR the carry into the top bit. This is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it.
- R4: After an operation resolves, `cycles` equals L + 1. L is the length of the longest run of adjacent bit positions in which `op_a` and `op_b` differ (L = 0 when no bits differ).
- R5: The edge that samples `start` high loads `cycles` with 1. `done` is first high after L further edges, so `done` rises on the edge that makes `cycles` reach L + 1. Until then `done` is low, and `cycles` rises by one per edge.
- R6: No bit position ever has both its carry-one and carry-zero rails at 1.
- R7: While `done` is high and `start` is low, `done`, `sum`, `carry_out`, `overflow` and `cycles` hold their values.
- R8: A `start` while an operation is still resolving discards that operation. The results and `cycles` then follow the new operands only.
- R9: After reset, `done`, `sum`, `carry_out`, `overflow` and `cycles` are all 0, and they stay 0 until the first `start`.
- R10: `cycles` never exceeds WIDTH + 1. An all-propagate operand pair (every bit differs) reports exactly WIDTH + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture operands and begin an addition |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum, valid while `done` is high |
| carry_out | output | 1 | Carry out of the top bit |
| overflow | output | 1 | Two's-complement overflow |
| done | output | 1 | Every carry position has resolved |
| cycles | output | $clog2(WIDTH+2) | Edges taken by the current operation |

## Verification
Some properties are checked on every cycle by assertions:
- no position ever shows both rails high;
- the results hold once resolved;
- `start` loads the count with 1;
- the count rises by one on each unresolved edge;
- the count stays within its bound.

Other behaviour depends on the operand values, so only the bench's scenarios show it. This covers the arithmetic value of the sum, carry and overflow flags. It also covers the exact resolution time as a function of the longest propagate run. The scenarios include all-propagate chains, runs that start at bit 0 from the carry input, signed overflow, and a restart in the middle of a long chain.

// File: rtl/cca_pkg.sv
package cca_pkg;
   // Per-bit carry behaviour of an operand pair
   typedef enum logic [1:0] {
      KIND_KILL = 2'd0,   // both bits zero: carry out is 0
      KIND_PROP = 2'd1,   // bits differ: carry out equals carry in
      KIND_GEN  = 2'd2    // both bits one: carry out is 1
   } bit_kind_e;
endpackage

// File: rtl/cca_classify.sv
module cca_classify
   import cca_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0]            x,
   input  logic [WIDTH-1:0]            y,
   output bit_kind_e [WIDTH-1:0]       kind
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign kind[i] = (x[i] & y[i]) ? KIND_GEN :
                       (x[i] ^ y[i]) ? KIND_PROP : KIND_KILL;
   end
endmodule

// File: rtl/cca_rail_chain.sv
module cca_rail_chain
   import cca_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  bit_kind_e [WIDTH-1:0] new_kind,
   input  logic                  carry_in,
   output bit_kind_e [WIDTH-1:0] kind_q,
   output logic [WIDTH-1:0]      rail_one,
   output logic [WIDTH-1:0]      rail_zero,
   output logic                  cin_q
);
   logic [WIDTH-1:0] below_one;
   logic [WIDTH-1:0] below_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cin_q <= 1'b0;
      else if (start) cin_q <= carry_in;
   end

   // Rails presented to each position by its lower neighbour; bit 0 sees the carry input
   assign below_one  = {rail_one[WIDTH-2:0],  cin_q};
   assign below_zero = {rail_zero[WIDTH-2:0], ~cin_q};

   for (genvar i = 0; i < WIDTH; i++) begin : g_pos
      bit_kind_e k_q;
      logic      one_q;
      logic      zero_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            k_q    <= KIND_KILL;
            one_q  <= 1'b0;
            zero_q <= 1'b0;
         end else if (start) begin
            k_q    <= new_kind[i];
            one_q  <= (new_kind[i] == KIND_GEN);
            zero_q <= (new_kind[i] == KIND_KILL);
         end else if (k_q == KIND_PROP) begin
            one_q  <= below_one[i];
            zero_q <= below_zero[i];
         end
      end

      assign kind_q[i]    = k_q;
      assign rail_one[i]  = one_q;
      assign rail_zero[i] = zero_q;
   end
endmodule

// File: rtl/cca_step_counter.sv
module cca_step_counter #(
   parameter int WIDTH = 16,
   parameter int CNT_W = $clog2(WIDTH + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             resolved,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WIDTH + 1);

   logic active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         count    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         count    <= CNT_W'(1);
      end else if (active_q && !resolved && count != CNT_MAX) begin
         count    <= count + CNT_W'(1);
      end
   end
endmodule

// File: rtl/carry_completion_adder.sv
module carry_completion_adder
   import cca_pkg::*;
#(
   parameter int WIDTH = 16,
   localparam int CNT_W = $clog2(WIDTH + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out,
   output logic             overflow,
   output logic             done,
   output logic [CNT_W-1:0] cycles
);
   if (WIDTH < 2) begin : g_width_bad
      $error("carry_completion_adder: WIDTH must be at least 2");
   end

   bit_kind_e [WIDTH-1:0] new_kind;
   bit_kind_e [WIDTH-1:0] kind_q;
   logic [WIDTH-1:0]      rail_one;
   logic [WIDTH-1:0]      rail_zero;
   logic                  cin_q;
   logic [WIDTH-1:0]      carry_into;

   cca_classify #(.WIDTH(WIDTH)) u_classify (
      .x    (op_a),
      .y    (op_b),
      .kind (new_kind)
   );

   cca_rail_chain #(.WIDTH(WIDTH)) u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .new_kind  (new_kind),
      .carry_in  (carry_in),
      .kind_q    (kind_q),
      .rail_one  (rail_one),
      .rail_zero (rail_zero),
      .cin_q     (cin_q)
   );

   // A position is resolved when either of its rails is set
   assign done = &(rail_one | rail_zero);

   cca_step_counter #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .resolved (done),
      .count    (cycles)
   );

   assign carry_into = {rail_one[WIDTH-2:0], cin_q};

   for (genvar i = 0; i < WIDTH; i++) begin : g_sum
      assign sum[i] = (kind_q[i] == KIND_PROP) ^ carry_into[i];
   end

   assign carry_out = rail_one[WIDTH-1];
   assign overflow  = rail_one[WIDTH-1] ^ rail_one[WIDTH-2];
endmodule

// File: rtl/cca_checker.sv
module cca_checker #(
   parameter int WIDTH = 16,
   parameter int CNT_W = $clog2(WIDTH + 2)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             done,
   input logic [WIDTH-1:0] rail_one,
   input logic [WIDTH-1:0] rail_zero,
   input logic [WIDTH-1:0] sum,
   input logic             carry_out,
   input logic             overflow,
   input logic [CNT_W-1:0] cycles
);
   // R6
   no_rail_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_one & rail_zero) == '0);

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(sum) && $stable(carry_out)
                            && $stable(overflow) && $stable(cycles)));

   // R5
   start_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cycles == CNT_W'(1)));

   // R5
   step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !done && cycles != '0 && cycles <= CNT_W'(WIDTH))
      |=> (cycles == $past(cycles) + CNT_W'(1)));

   // R10
   cycle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cycles <= CNT_W'(WIDTH + 1));
endmodule

bind carry_completion_adder cca_checker #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .done      (done),
   .rail_one  (rail_one),
   .rail_zero (rail_zero),
   .sum       (sum),
   .carry_out (carry_out),
   .overflow  (overflow),
   .cycles    (cycles)
);

// File: tb/test_carry_completion_adder.sv
module test_carry_completion_adder;
   localparam int W     = 16;
   localparam int CW    = $clog2(W + 2);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  op_a = '0;
   logic [W-1:0]  op_b = '0;
   logic          carry_in = 1'b0;
   logic [W-1:0]  sum;
   logic          carry_out;
   logic          overflow;
   logic          done;
   logic [CW-1:0] cycles;

   int tests = 0;
   int failed = 0;

   always #4 clk = ~clk;   // 125 MHz

   carry_completion_adder #(.WIDTH(W)) i_carry_completion_adder (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .carry_in(carry_in), .sum(sum), .carry_out(carry_out),
      .overflow(overflow), .done(done), .cycles(cycles)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         failed++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int longest_run(input logic [W-1:0] a, input logic [W-1:0] b);
      int best = 0;
      int cur = 0;
      for (int i = 0; i < W; i++) begin
         if (a[i] ^ b[i]) begin
            cur++;
            if (cur > best) best = cur;
         end else begin
            cur = 0;
         end
      end
      return best;
   endfunction

   // Behavioural reference, advanced on every rising edge
   bit            m_active = 0;
   int            m_run = 0;
   int            m_k = 0;
   int            m_cyc = 0;
   logic [W:0]    m_full = '0;
   logic          m_ovf = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_active = 0; m_k = 0; m_cyc = 0;
      end else if (start) begin
         m_active = 1;
         m_run    = longest_run(op_a, op_b);
         m_k      = 0;
         m_cyc    = 1;
         m_full   = {1'b0, op_a} + {1'b0, op_b} + (W+1)'(carry_in);
         m_ovf    = (op_a[W-1] == op_b[W-1]) && (m_full[W-1] != op_a[W-1]);
      end else if (m_active && m_k < m_run) begin
         m_k++;
         m_cyc++;
      end
   end

   // Per-cycle comparison away from the rising edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit exp_done;
         exp_done = m_active && (m_k >= m_run);
         chk(done == exp_done, "R5 done", done, exp_done);
         chk(cycles == CW'(m_cyc), "R4 cycles", cycles, m_cyc);
         chk(cycles <= CW'(W + 1), "R10 bound", cycles, W + 1);
         if (exp_done) begin
            // R7: repeated each cycle while resolved, so values must hold
            chk(sum == m_full[W-1:0], "R1 sum (R7 hold)", sum, m_full[W-1:0]);
            chk(carry_out == m_full[W], "R2 carry_out", carry_out, m_full[W]);
            chk(overflow == m_ovf, "R3 overflow", overflow, m_ovf);
         end
      end
   end

   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci, input int hold);
      @(negedge clk);
      op_a = a; op_b = b; carry_in = ci; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n < W + 4 && !done; n++) @(negedge clk);
      // R4: resolved count equals longest propagate run plus one
      chk(cycles == CW'(longest_run(a, b) + 1), "R4 final cycles", cycles, longest_run(a, b) + 1);
      // R1 / R6: a rail clash or missing rail would corrupt the resolved sum
      chk(sum == W'(a + b + W'(ci)), "R1 R6 final sum", sum, W'(a + b + W'(ci)));
      repeat (hold) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset values
      chk(done == 1'b0, "R9 done", done, 0);
      chk(cycles == '0, "R9 cycles", cycles, 0);
      chk(sum == '0, "R9 sum", sum, 0);
      chk(carry_out == 1'b0 && overflow == 1'b0, "R9 flags", {carry_out, overflow}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(done == 1'b0 && cycles == '0, "R9 idle after reset", {done, cycles}, 0);

      run_op(16'h0000, 16'h0000, 1'b0, 2);   // no propagate: one cycle
      run_op(16'hFFFF, 16'hFFFF, 1'b1, 2);   // all generate
      run_op(16'hFFFF, 16'h0000, 1'b1, 3);   // R10: full chain from carry_in
      chk(cycles == CW'(W + 1), "R10 all-propagate", cycles, W + 1);
      chk(carry_out == 1'b1 && sum == '0, "R2 chain carry", {carry_out, sum}, 17'h10000);
      run_op(16'h7FFF, 16'h0001, 1'b0, 2);   // R3: positive overflow
      chk(overflow == 1'b1, "R3 pos overflow", overflow, 1);
      run_op(16'h8000, 16'h8000, 1'b0, 2);   // R3: negative overflow
      chk(overflow == 1'b1 && carry_out == 1'b1, "R3 neg overflow", {overflow, carry_out}, 3);
      run_op(16'h00F0, 16'h0F00, 1'b0, 2);   // run of 8 in the middle
      run_op(16'hAAAA, 16'h5555, 1'b0, 4);   // R7 hold over several cycles

      // R8: restart mid-chain
      @(negedge clk);
      op_a = 16'hFFFF; op_b = 16'h0000; carry_in = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R8 busy before restart", done, 0);
      run_op(16'h0003, 16'h0001, 1'b0, 2);
      chk(sum == 16'h0004 && cycles == CW'(2), "R8 restart result", {sum, cycles}, {16'h0004, CW'(2)});

      for (int n = 0; n < 40; n++) begin
         run_op(W'($urandom), W'($urandom), 1'($urandom), 1);
      end

      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end
endmodule